// File: doc/BRIEF.md
# Internal Bus Interface Unit

This block connects a simple processor request port to an on-chip address/data bus. The bus serves three regions: read-only program memory, working RAM, and a window of special-function registers. When the processor issues a request, the unit latches the address. For a write it also latches the outgoing data. It then runs one bus cycle and returns to idle. For a read, the processor waits until the unit has captured the bus data into its read buffer, and then uses the buffered value.

The length of a bus cycle depends on the region. RAM and register-window cycles always take two clocks. Program-memory cycles take two or three clocks, chosen by a speed bit that the unit holds itself. Software sets that bit by writing to a fixed register address. The bit comes out of reset at the slow setting. A force input keeps program-memory cycles slow while the memory is being reprogrammed.

The state machine has four states. IDLE accepts a request (transition ACCEPT). ADDR is the first clock, in which the address is driven. It goes either to HOLD (transition EXTEND, taken for a slow program-memory cycle) or straight to LAST (transition SHORT). HOLD always moves on to LAST (transition FINISH). LAST is the final clock, in which done is raised, write data is strobed and read data is sampled. It returns to IDLE (transition RETIRE).

Top module: `ibus_unit`

## Requirements
- R1: After reset, busy, done, bus_we and bus_sel are all 0, rdata is 0, and the program-memory speed bit is 0, so the first program-memory cycle takes three clocks.
- R2: A request (req_valid high) is accepted only in IDLE. A request presented while busy is ignored, and bus_addr keeps the address of the cycle in progress.
- R3: Region decode uses the latched address only. Addresses 0x0000–0x007F are the register window (bus_sel = 3'b001), 0x0080–0x7FFF are RAM (3'b010), and 0x8000–0xFFFF are program memory (3'b100). bus_sel is one-hot while busy and zero in IDLE.
- R4: RAM and register-window cycles last exactly two clocks, with busy high for two cycles and done in the second.
- R5: A program-memory cycle lasts three clocks while the speed bit is 0 and two clocks while it is 1.
- R6: A write to address 0x005F loads the speed bit from req_wdata bit 7. A read of 0x005F returns the speed bit in rdata bit 7, with all other bits 0.
- R7: While flash_force_slow is 1, program-memory cycles take three clocks whatever the speed bit holds.
- R8: A read samples bus_rdata in the final clock of the cycle. rdata shows that value from the following clock until the next read completes.
- R9: For a RAM or register write, bus_we is high only in the final clock, and bus_wdata then equals the buffered write data.
- R10: A write to program memory completes with normal cycle timing and never raises bus_we.
- R11: done is a single-clock pulse in the final clock of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| flash_force_slow | input | 1 | Forces three-clock program-memory cycles |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | Final clock of a bus cycle |
| rdata | output | 8 | Read buffer |
| bus_addr | output | 16 | Internal address bus |
| bus_sel | output | 3 | One-hot region select: {program memory, RAM, registers} |
| bus_we | output | 1 | Write strobe |
| bus_wdata | output | 8 | Internal write data |
| bus_rdata | input | 8 | Internal read data |

## Verification
The request is accepted at the first rising edge after req_valid is seen. From that point, done is due one clock later for a two-clock cycle and two clocks later for a three-clock cycle. rdata is due one clock after done. The bench drives and samples on falling edges. It counts each clock in which busy is high up to the one that shows done, compares that count with the expected cycle length, and checks bus_we and bus_wdata in that same clock. It reads rdata and the return to idle on the next falling edge.

// File: rtl/ibus_pkg.sv
package ibus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HOLD = 2'd2,
        ST_LAST = 2'd3
    } ibus_state_t;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_REG  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_RAM  = 3'b010;
    localparam logic [SEL_W-1:0] SEL_PROG = 3'b100;
endpackage

// File: rtl/ibus_region_dec.sv
module ibus_region_dec #(
    parameter int AW = 16,
    parameter logic [AW-1:0] REG_TOP   = 16'h007F,
    parameter logic [AW-1:0] PROG_BASE = 16'h8000
) (
    input  logic [AW-1:0] addr,
    output logic [2:0]    sel
);
    import ibus_pkg::*;

    always_comb begin
        if (addr >= PROG_BASE)
            sel = SEL_PROG;
        else if (addr <= REG_TOP)
            sel = SEL_REG;
        else
            sel = SEL_RAM;
    end
endmodule

// File: rtl/ibus_speed_reg.sv
module ibus_speed_reg #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] CTL_ADDR = 16'h005F,
    parameter int CTL_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          force_slow,
    output logic          hit,
    output logic          fast_eff,
    output logic [DW-1:0] rd_value
);
    logic speed_q;

    assign hit      = (wr_addr == CTL_ADDR);
    assign fast_eff = speed_q & ~force_slow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            speed_q <= 1'b0;
        else if (wr_fire && hit)
            speed_q <= wr_data[CTL_BIT];
    end

    always_comb begin
        rd_value          = '0;
        rd_value[CTL_BIT] = speed_q;
    end
endmodule

// File: rtl/ibus_databuf.sv
module ibus_databuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_w,
    input  logic [DW-1:0] w_in,
    input  logic          cap_r,
    input  logic [DW-1:0] r_in,
    output logic [DW-1:0] w_buf,
    output logic [DW-1:0] r_buf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_buf <= '0;
            r_buf <= '0;
        end else begin
            if (load_w) w_buf <= w_in;
            if (cap_r)  r_buf <= r_in;
        end
    end
endmodule

// File: rtl/ibus_unit.sv
module ibus_unit #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] REG_TOP   = 16'h007F,
    parameter logic [AW-1:0] PROG_BASE = 16'h8000,
    parameter logic [AW-1:0] CTL_ADDR  = 16'h005F,
    parameter int CTL_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          flash_force_slow,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [2:0]    bus_sel,
    output logic          bus_we,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    import ibus_pkg::*;

    ibus_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [2:0]    region;
    logic          accept;
    logic          is_last;
    logic          ctl_hit;
    logic          fast_eff;
    logic [DW-1:0] ctl_value;
    logic [DW-1:0] w_buf;
    logic [DW-1:0] cap_value;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign is_last = (state_q == ST_LAST);

    // address register and direction flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            we_q   <= req_we;
        end
    end

    ibus_region_dec #(
        .AW(AW), .REG_TOP(REG_TOP), .PROG_BASE(PROG_BASE)
    ) u_dec (
        .addr (addr_q),
        .sel  (region)
    );

    ibus_speed_reg #(
        .AW(AW), .DW(DW), .CTL_ADDR(CTL_ADDR), .CTL_BIT(CTL_BIT)
    ) u_speed (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (is_last && we_q),
        .wr_addr    (addr_q),
        .wr_data    (w_buf),
        .force_slow (flash_force_slow),
        .hit        (ctl_hit),
        .fast_eff   (fast_eff),
        .rd_value   (ctl_value)
    );

    assign cap_value = ctl_hit ? ctl_value : bus_rdata;

    ibus_databuf #(.DW(DW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_w (accept && req_we),
        .w_in   (req_wdata),
        .cap_r  (is_last && !we_q),
        .r_in   (cap_value),
        .w_buf  (w_buf),
        .r_buf  (rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT, EXTEND, SHORT, FINISH, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ADDR;
            ST_ADDR: state_d = (region == SEL_PROG && !fast_eff) ? ST_HOLD : ST_LAST;
            ST_HOLD: state_d = ST_LAST;
            ST_LAST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        bus_sel   = '0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        bus_addr  = addr_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR, ST_HOLD: begin
                busy    = 1'b1;
                bus_sel = region;
            end
            ST_LAST: begin
                busy    = 1'b1;
                done    = 1'b1;
                bus_sel = region;
                if (we_q && region != SEL_PROG) begin
                    bus_we    = 1'b1;
                    bus_wdata = w_buf;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ibus_unit_chk.sv
module ibus_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [2:0]    bus_sel,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr
);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(bus_addr));

    a_r9_strobe_last: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> done);

    a_r10_no_prog_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !bus_sel[2]);

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(bus_sel) == 1));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_sel == 3'b000 && !bus_we && !done));

    a_r4_two_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bus_sel[2]) |-> ($past(busy) && !$past(done)));
endmodule

bind ibus_unit ibus_unit_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr)
);

// File: tb/ibus_unit_tb.sv
module ibus_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        flash_force_slow = 1'b0;
    logic        busy, done, bus_we;
    logic [7:0]  rdata, bus_wdata, bus_rdata;
    logic [15:0] bus_addr;
    logic [2:0]  bus_sel;

    int total = 0;
    int bad = 0;

    int         l_n;
    logic [2:0] l_sel;
    logic       l_we;
    logic [7:0] l_wd;
    logic       l_early;
    logic       l_done_after;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign bus_rdata = mem(bus_addr);

    ibus_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .flash_force_slow(flash_force_slow), .busy(busy), .done(done),
        .rdata(rdata), .bus_addr(bus_addr), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one complete access; results left in l_* variables
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        l_n = 0; l_early = 1'b0; l_sel = '0; l_we = 1'b0; l_wd = '0;
        for (int i = 0; i < 10; i++) begin
            if (!busy) break;
            l_n++;
            if (done) begin
                l_sel = bus_sel; l_we = bus_we; l_wd = bus_wdata;
                break;
            end
            if (bus_we) l_early = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        l_done_after = done | busy;
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 sel", bus_sel, 0);
        check("R1 we", bus_we, 0);
        check("R1 rdata", rdata, 0);
        access(1'b0, 16'h9000, 8'h00);
        check("R1 R5 slow default len", l_n, 3);
        check("R3 prog sel", l_sel, 3'b100);
        check("R8 prog rdata", rdata, mem(16'h9000));
        check("R11 done pulse", l_done_after, 0);
    endtask

    task automatic t_regions;
        access(1'b0, 16'h1234, 8'h00);
        check("R4 ram len", l_n, 2);
        check("R3 ram sel", l_sel, 3'b010);
        check("R8 ram rdata", rdata, mem(16'h1234));
        access(1'b0, 16'h0010, 8'h00);
        check("R4 reg len", l_n, 2);
        check("R3 reg sel", l_sel, 3'b001);
        check("R8 reg rdata", rdata, mem(16'h0010));
        access(1'b0, 16'h007F, 8'h00);
        check("R3 edge 007F", l_sel, 3'b001);
        access(1'b0, 16'h0080, 8'h00);
        check("R3 edge 0080", l_sel, 3'b010);
        access(1'b0, 16'h7FFF, 8'h00);
        check("R3 edge 7FFF", l_sel, 3'b010);
        access(1'b0, 16'h8000, 8'h00);
        check("R3 edge 8000", l_sel, 3'b100);
        check("R5 edge 8000 len", l_n, 3);
    endtask

    task automatic t_write;
        logic [7:0] keep;
        keep = rdata;
        access(1'b1, 16'h0200, 8'h3C);
        check("R9 len", l_n, 2);
        check("R9 strobe last", l_we, 1);
        check("R9 wdata", l_wd, 8'h3C);
        check("R9 no early strobe", l_early, 0);
        check("R8 rdata held over write", rdata, keep);
    endtask

    task automatic t_speed;
        access(1'b1, 16'h005F, 8'h80);
        access(1'b0, 16'h005F, 8'h00);
        check("R6 readback set", rdata, 8'h80);
        access(1'b0, 16'hA000, 8'h00);
        check("R5 fast len", l_n, 2);
        check("R8 fast rdata", rdata, mem(16'hA000));
        flash_force_slow = 1'b1;
        access(1'b0, 16'hA000, 8'h00);
        check("R7 forced slow len", l_n, 3);
        access(1'b0, 16'h0300, 8'h00);
        check("R7 ram unaffected", l_n, 2);
        flash_force_slow = 1'b0;
        access(1'b0, 16'hA000, 8'h00);
        check("R7 released len", l_n, 2);
    endtask

    task automatic t_prog_write;
        access(1'b1, 16'h8100, 8'hEE);
        check("R10 fast len", l_n, 2);
        check("R10 no strobe", l_we | l_early, 0);
        access(1'b1, 16'h005F, 8'h7F);
        access(1'b0, 16'h005F, 8'h00);
        check("R6 readback clear", rdata, 8'h00);
        access(1'b1, 16'hC000, 8'h11);
        check("R10 slow len", l_n, 3);
        check("R10 slow no strobe", l_we | l_early, 0);
    endtask

    task automatic t_ignore_busy;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h0400;
        @(negedge clk);
        req_addr = 16'h0500; req_we = 1'b1;
        check("R2 busy first", busy, 1);
        @(negedge clk);
        check("R2 addr kept", bus_addr, 16'h0400);
        check("R2 done second", done, 1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle after", busy, 0);
        check("R2 read kept", rdata, mem(16'h0400));
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regions();
        t_write();
        t_speed();
        t_prog_write();
        t_ignore_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule